// File: doc/BRIEF.md
# Eighth-Wave FFT Twiddle Generator

This block supplies the twiddle factors W_k = exp(-j2πk/N) that a radix-2 FFT needs, for every index k from 0 to N/2-1. It holds only N/8+1 complex coefficients. These cover the first eighth of the unit circle, angles 0 to π/4. Every other factor is rebuilt from one stored entry by mirroring the table address and by swapping and negating the real and imaginary parts.

A butterfly sequencer presents an index on `k_idx` and raises `k_valid`. The index is sorted into one of four regions. As k counts upward, the region moves from FIRST to MIRROR, then to QUARTER, and last to BACK:

- FIRST covers k = 0 to N/8. The value is read directly from the table.
- MIRROR covers N/8 < k < N/4. The table is read at N/4-k. The output real part is minus the stored imaginary part, and the output imaginary part is minus the stored real part.
- QUARTER covers N/4 to 3N/8. The table is read at k-N/4. The output real part is the stored imaginary part, and the output imaginary part is minus the stored real part.
- BACK covers 3N/8 < k < N/2. The table is read at N/2-k. The output real part is the negated stored real part, and the imaginary part is kept.

The rebuilt factor is registered and appears one clock later with `tw_valid`. The table contents are computed at elaboration from the parameters. The real and imaginary parts are rounded to signed Q(COEF_W-1), scaled so that 1.0 is 2^(COEF_W-1)-1. Negation saturates, so the most negative code never wraps.

Top module: `twiddle_gen_top`

## Requirements
- R1: While `rst_n` is low and after its release, before any index is accepted, `tw_valid` is 0 and `tw_re`/`tw_im` are 0.
- R2: `tw_valid` is high in exactly the cycles that follow a clock edge at which `k_valid` was high; each accepted index yields exactly one result, in order.
- R3: For k in FIRST (0..N/8), `tw_re`/`tw_im` (signed two's complement) are within 1 LSB of round(M·cos(2πk/N)) and round(-M·sin(2πk/N)), with M = 2^(COEF_W-1)-1; k = 0 gives (M, 0).
- R4: For k in MIRROR (N/8 < k < N/4), the outputs are within 1 LSB of the same reference.
- R5: For k in QUARTER (N/4..3N/8), the outputs are within 1 LSB of the reference; k = N/4 gives exactly (0, -M).
- R6: For k in BACK (3N/8 < k < N/2), the outputs are within 1 LSB of the reference.
- R7: With FFT_N = 32 every one of the 16 factors meets the 1 LSB bound; k = 1 is about (0.98, -0.19) and k = 4 about (0.71, -0.71).
- R8: A clock edge with `k_valid` low leaves `tw_re` and `tw_im` unchanged.
- R9: At k = N/8 the result is exactly symmetric: `tw_re` equals the negation of `tw_im`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| k_valid | input | 1 | Index strobe |
| k_idx | input | log2(FFT_N)-1 | Twiddle index k |
| tw_valid | output | 1 | Result strobe, one cycle after `k_valid` |
| tw_re | output | COEF_W | Real part, signed |
| tw_im | output | COEF_W | Imaginary part, signed |

## Verification
Every result is due exactly one rising edge after the edge that accepted its index. The region decode, table read and swap/negate logic are all combinational ahead of a single output register. The driver changes inputs on the falling edge and pushes the reference value for each index into a queue. The monitor samples one time unit after each rising edge, pops exactly one entry whenever `tw_valid` is high, and reports a strobe with nothing pending, or entries left over at the end, as a latency fault. In cycles with `tw_valid` low, the monitor compares the outputs with the last result to confirm that they held.

// File: rtl/twg_pkg.sv
package twg_pkg;

    typedef enum logic [1:0] {
        REG_FIRST   = 2'd0,
        REG_MIRROR  = 2'd1,
        REG_QUARTER = 2'd2,
        REG_BACK    = 2'd3
    } twg_region_e;

    localparam real TWG_PI = 3.14159265358979323846;

    // Series cosine, accurate far below 1 LSB for |x| <= pi/4
    function automatic real series_cos(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int n = 1; n <= 10; n++) begin
            term = -term * x * x / real'((2 * n - 1) * (2 * n));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic real series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n <= 10; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic int round_sym(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // Stored real part of entry idx for an fft_n-point transform
    function automatic int coef_re(input int idx, input int fft_n, input int cw);
        real ang;
        ang = 2.0 * TWG_PI * real'(idx) / real'(fft_n);
        return round_sym(real'((1 << (cw - 1)) - 1) * series_cos(ang));
    endfunction

    // Stored imaginary part: minus the sine
    function automatic int coef_im(input int idx, input int fft_n, input int cw);
        real ang;
        ang = 2.0 * TWG_PI * real'(idx) / real'(fft_n);
        return round_sym(-real'((1 << (cw - 1)) - 1) * series_sin(ang));
    endfunction

endpackage

// File: rtl/twg_region_decode.sv
module twg_region_decode #(
    parameter int FFT_N  = 256,
    parameter int IDX_W  = $clog2(FFT_N) - 1,
    parameter int ADDR_W = IDX_W - 1
) (
    input  logic [IDX_W-1:0]         k_idx,
    output twg_pkg::twg_region_e     region,
    output logic [ADDR_W-1:0]        rom_addr
);
    import twg_pkg::*;

    localparam int K_EIGHTH   = FFT_N / 8;
    localparam int K_QUARTER  = FFT_N / 4;
    localparam int K_3EIGHTH  = 3 * FFT_N / 8;

    logic [ADDR_W-1:0] low_bits;
    assign low_bits = k_idx[ADDR_W-1:0];

    always_comb begin
        if (k_idx <= IDX_W'(K_EIGHTH))
            region = REG_FIRST;
        else if (k_idx < IDX_W'(K_QUARTER))
            region = REG_MIRROR;
        else if (k_idx <= IDX_W'(K_3EIGHTH))
            region = REG_QUARTER;
        else
            region = REG_BACK;
    end

    // Mirrored regions read at (N/4 - k) mod N/4, the two's complement of the low bits
    always_comb begin
        unique case (region)
            REG_FIRST:   rom_addr = low_bits;
            REG_MIRROR:  rom_addr = ADDR_W'(0) - low_bits;
            REG_QUARTER: rom_addr = low_bits;
            REG_BACK:    rom_addr = ADDR_W'(0) - low_bits;
            default:     rom_addr = low_bits;
        endcase
    end

endmodule

// File: rtl/twg_coef_rom.sv
module twg_coef_rom #(
    parameter int FFT_N  = 256,
    parameter int COEF_W = 16,
    parameter int ADDR_W = $clog2(FFT_N) - 2
) (
    input  logic [ADDR_W-1:0]        rom_addr,
    output logic signed [COEF_W-1:0] rd_re,
    output logic signed [COEF_W-1:0] rd_im
);
    localparam int ROM_DEPTH = FFT_N / 8 + 1;

    logic signed [COEF_W-1:0] tab_re [ROM_DEPTH];
    logic signed [COEF_W-1:0] tab_im [ROM_DEPTH];

    for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_entry
        localparam int VAL_RE = twg_pkg::coef_re(gi, FFT_N, COEF_W);
        localparam int VAL_IM = twg_pkg::coef_im(gi, FFT_N, COEF_W);
        assign tab_re[gi] = VAL_RE[COEF_W-1:0];
        assign tab_im[gi] = VAL_IM[COEF_W-1:0];
    end

    always_comb begin
        rd_re = '0;
        rd_im = '0;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            if (rom_addr == ADDR_W'(i)) begin
                rd_re = tab_re[i];
                rd_im = tab_im[i];
            end
        end
    end

endmodule

// File: rtl/twg_reconstruct.sv
module twg_reconstruct #(
    parameter int COEF_W = 16
) (
    input  twg_pkg::twg_region_e     region,
    input  logic signed [COEF_W-1:0] rd_re,
    input  logic signed [COEF_W-1:0] rd_im,
    output logic signed [COEF_W-1:0] rec_re,
    output logic signed [COEF_W-1:0] rec_im
);
    import twg_pkg::*;

    localparam logic signed [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};
    localparam logic signed [COEF_W-1:0] MOST_POS = {1'b0, {(COEF_W-1){1'b1}}};

    function automatic logic signed [COEF_W-1:0] neg_sat(input logic signed [COEF_W-1:0] v);
        if (v == MOST_NEG) return MOST_POS;
        return -v;
    endfunction

    always_comb begin
        unique case (region)
            REG_FIRST: begin
                rec_re = rd_re;
                rec_im = rd_im;
            end
            REG_MIRROR: begin
                rec_re = neg_sat(rd_im);
                rec_im = neg_sat(rd_re);
            end
            REG_QUARTER: begin
                rec_re = rd_im;
                rec_im = neg_sat(rd_re);
            end
            REG_BACK: begin
                rec_re = neg_sat(rd_re);
                rec_im = rd_im;
            end
            default: begin
                rec_re = rd_re;
                rec_im = rd_im;
            end
        endcase
    end

endmodule

// File: rtl/twiddle_gen_top.sv
module twiddle_gen_top #(
    parameter int FFT_N  = 256,
    parameter int COEF_W = 16,
    parameter int IDX_W  = $clog2(FFT_N) - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     k_valid,
    input  logic [IDX_W-1:0]         k_idx,
    output logic                     tw_valid,
    output logic signed [COEF_W-1:0] tw_re,
    output logic signed [COEF_W-1:0] tw_im
);
    import twg_pkg::*;

    localparam int ADDR_W = IDX_W - 1;

    twg_region_e              region;
    logic [ADDR_W-1:0]        rom_addr;
    logic signed [COEF_W-1:0] rd_re;
    logic signed [COEF_W-1:0] rd_im;
    logic signed [COEF_W-1:0] rec_re;
    logic signed [COEF_W-1:0] rec_im;

    twg_region_decode #(
        .FFT_N (FFT_N),
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W)
    ) decode_i (
        .k_idx   (k_idx),
        .region  (region),
        .rom_addr(rom_addr)
    );

    twg_coef_rom #(
        .FFT_N (FFT_N),
        .COEF_W(COEF_W),
        .ADDR_W(ADDR_W)
    ) rom_i (
        .rom_addr(rom_addr),
        .rd_re   (rd_re),
        .rd_im   (rd_im)
    );

    twg_reconstruct #(
        .COEF_W(COEF_W)
    ) recon_i (
        .region(region),
        .rd_re (rd_re),
        .rd_im (rd_im),
        .rec_re(rec_re),
        .rec_im(rec_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_valid <= 1'b0;
        end else begin
            tw_valid <= k_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_re <= '0;
            tw_im <= '0;
        end else if (k_valid) begin
            tw_re <= rec_re;
            tw_im <= rec_im;
        end
    end

endmodule

// File: rtl/twg_checker.sv
module twg_checker #(
    parameter int FFT_N  = 256,
    parameter int COEF_W = 16,
    parameter int IDX_W  = $clog2(FFT_N) - 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     k_valid,
    input logic [IDX_W-1:0]         k_idx,
    input logic                     tw_valid,
    input logic signed [COEF_W-1:0] tw_re,
    input logic signed [COEF_W-1:0] tw_im
);
    localparam logic signed [COEF_W-1:0] POS_FULL = {1'b0, {(COEF_W-1){1'b1}}};
    localparam logic signed [COEF_W-1:0] NEG_FULL = {1'b1, {(COEF_W-2){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0]         K_QTR    = IDX_W'(FFT_N / 4);
    localparam logic [IDX_W-1:0]         K_OCT    = IDX_W'(FFT_N / 8);

    // R1: reset clears the strobe
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !tw_valid);

    // R2: strobe follows the accepted index by one edge
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        k_valid |=> tw_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !k_valid |=> !tw_valid);

    // R3: k = 0 yields full-scale real, zero imaginary
    a_r3_dc_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_idx == '0) |=> (tw_re == POS_FULL && tw_im == '0));

    // R5: k = N/4 yields zero real, negative full scale imaginary
    a_r5_quarter_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_idx == K_QTR) |=> (tw_re == '0 && tw_im == NEG_FULL));

    // R8: idle edges keep the result
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !k_valid |=> ($stable(tw_re) && $stable(tw_im)));

    // R9: exact symmetry at the eighth-wave point
    a_r9_eighth_symmetry: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_idx == K_OCT) |=> (tw_re == -tw_im));

endmodule

bind twiddle_gen_top twg_checker #(
    .FFT_N (FFT_N),
    .COEF_W(COEF_W),
    .IDX_W (IDX_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_valid (k_valid),
    .k_idx   (k_idx),
    .tw_valid(tw_valid),
    .tw_re   (tw_re),
    .tw_im   (tw_im)
);

// File: tb/twiddle_gen_top_tb_top.sv
module twiddle_gen_top_tb_top;

    localparam int NB   = 256;
    localparam int NS   = 32;
    localparam int CW   = 16;
    localparam int IWB  = $clog2(NB) - 1;
    localparam int IWS  = $clog2(NS) - 1;
    localparam int FULL = (1 << (CW - 1)) - 1;
    localparam real PI  = 3.14159265358979323846;

    typedef struct {
        int k;
        int re;
        int im;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic                 kv_b = 1'b0;
    logic [IWB-1:0]       k_b = '0;
    logic                 tv_b;
    logic signed [CW-1:0] re_b, im_b;

    logic                 kv_s = 1'b0;
    logic [IWS-1:0]       k_s = '0;
    logic                 tv_s;
    logic signed [CW-1:0] re_s, im_s;

    twiddle_gen_top #(.FFT_N(NB), .COEF_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .k_valid(kv_b), .k_idx(k_b),
        .tw_valid(tv_b), .tw_re(re_b), .tw_im(im_b));

    twiddle_gen_top #(.FFT_N(NS), .COEF_W(CW)) dut32_i (
        .clk(clk), .rst_n(rst_n), .k_valid(kv_s), .k_idx(k_s),
        .tw_valid(tv_s), .tw_re(re_s), .tw_im(im_s));

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;
    exp_t q_b[$];
    exp_t q_s[$];

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic exp_t ref_of(input int k, input int n);
        exp_t e;
        real a;
        a = 2.0 * PI * real'(k) / real'(n);
        e.k  = k;
        e.re = rnd(real'(FULL) * $cos(a));
        e.im = rnd(-real'(FULL) * $sin(a));
        return e;
    endfunction

    function automatic string tag_of(input int k, input int n);
        if (k <= n / 8) return "R3";
        if (k < n / 4) return "R4";
        if (k <= 3 * n / 8) return "R5";
        return "R6";
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act_a, input int act_b, input int exp_a, input int exp_b);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=(%0d,%0d) expected=(%0d,%0d)",
                     req, what, act_a, act_b, exp_a, exp_b);
        end
    endtask

    task automatic send_b(input int k);
        @(negedge clk);
        kv_b = 1'b1;
        k_b  = IWB'(k);
        q_b.push_back(ref_of(k, NB));
    endtask

    task automatic send_s(input int k);
        @(negedge clk);
        kv_s = 1'b1;
        k_s  = IWS'(k);
        q_s.push_back(ref_of(k, NS));
    endtask

    task automatic idle_b();
        @(negedge clk);
        kv_b = 1'b0;
    endtask

    // Monitor for the 256-point instance
    initial begin
        int lre, lim;
        bit seen;
        exp_t e;
        seen = 1'b0;
        lre = 0;
        lim = 0;
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (tv_b) begin
                    if (q_b.size() == 0) begin
                        check(1'b0, "R2", "strobe with nothing pending", 1, 0, 0, 0);
                    end else begin
                        e = q_b.pop_front();
                        check(iabs(int'(re_b) - e.re) <= 1 && iabs(int'(im_b) - e.im) <= 1,
                              tag_of(e.k, NB), $sformatf("N=256 k=%0d", e.k),
                              int'(re_b), int'(im_b), e.re, e.im);
                        if (e.k == 0)
                            check(int'(re_b) == FULL && int'(im_b) == 0, "R3", "k=0 exact",
                                  int'(re_b), int'(im_b), FULL, 0);
                        if (e.k == NB / 4)
                            check(int'(re_b) == 0 && int'(im_b) == -FULL, "R5", "k=N/4 exact",
                                  int'(re_b), int'(im_b), 0, -FULL);
                        if (e.k == NB / 8)
                            check(int'(re_b) == -int'(im_b), "R9", "k=N/8 symmetry",
                                  int'(re_b), int'(im_b), -int'(im_b), int'(im_b));
                        lre = int'(re_b);
                        lim = int'(im_b);
                        seen = 1'b1;
                    end
                end else if (seen) begin
                    check(int'(re_b) == lre && int'(im_b) == lim, "R8", "hold on idle",
                          int'(re_b), int'(im_b), lre, lim);
                end
            end
        end
    end

    // Monitor for the 32-point instance
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && tv_s) begin
                if (q_s.size() == 0) begin
                    check(1'b0, "R2", "N=32 strobe with nothing pending", 1, 0, 0, 0);
                end else begin
                    e = q_s.pop_front();
                    check(iabs(int'(re_s) - e.re) <= 1 && iabs(int'(im_s) - e.im) <= 1,
                          "R7", $sformatf("N=32 k=%0d", e.k),
                          int'(re_s), int'(im_s), e.re, e.im);
                end
            end
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!tv_b && re_b == '0 && im_b == '0, "R1", "in reset",
              int'(tv_b), int'(re_b), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!tv_b && !tv_s && re_b == '0 && im_b == '0, "R1", "after release",
              int'(tv_b), int'(re_b), 0, 0);
        mon_on = 1'b1;

        // Back-to-back sweep over every index
        for (int k = 0; k < NB / 2; k++) send_b(k);
        idle_b();

        // Bubbled pattern around region boundaries
        for (int j = 0; j < 8; j++) begin
            int kk;
            case (j)
                0: kk = NB / 8;
                1: kk = NB / 8 + 1;
                2: kk = NB / 4 - 1;
                3: kk = NB / 4;
                4: kk = 3 * NB / 8;
                5: kk = 3 * NB / 8 + 1;
                6: kk = NB / 2 - 1;
                default: kk = 0;
            endcase
            send_b(kk);
            idle_b();
            idle_b();
        end

        // Descending sweep
        for (int k = NB / 2 - 1; k >= 0; k -= 7) send_b(k);
        idle_b();

        // 32-point table
        for (int k = 0; k < NS / 2; k++) send_s(k);
        @(negedge clk);
        kv_s = 1'b0;

        repeat (4) @(posedge clk);
        #1;
        check(q_b.size() == 0 && q_s.size() == 0, "R2", "all results delivered",
              q_b.size(), q_s.size(), 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule